// File: doc/BRIEF.md
# Page-Mode Read Port

This block is the read side of a word-organized memory. It answers plain asynchronous reads and fast page-mode reads. A clock models access time: every read completes after a number of clock edges set by a parameter.

Page mode is on from reset, and it covers the whole array. The first read after chip enable falls takes the full latency. When that read completes, the page holding the word is open. While chip enable stays low, an address change that touches only the within-page bits finishes in the short page latency. Any change above the page field takes the full latency again.

Taking chip enable high closes the page. It also turns the output off, shown as an output-enable flag at 0. A small preload write port fills the array before or between reads.

The controller is one state machine with four states:
- `PM_IDLE`: chip enable is high and the output is off.
- `PM_FULL_WAIT`: counting the full latency.
- `PM_PAGE_WAIT`: counting the page latency.
- `PM_HOLD`: the word is valid and held.

Its transitions are:
- IDLE→FULL_WAIT when chip enable is sampled low.
- FULL_WAIT→HOLD when the count ends; this opens the page.
- PAGE_WAIT→HOLD when the count ends.
- HOLD→PAGE_WAIT on a within-page address change.
- HOLD→FULL_WAIT on a change above the page field; this closes the page.
- FULL_WAIT→FULL_WAIT restarts the count on any address change.
- PAGE_WAIT→PAGE_WAIT restarts the count on a within-page change.
- PAGE_WAIT→FULL_WAIT on a change above the page field.
- Any state→IDLE when chip enable is sampled high.

Top module: `page_read_port`

## Requirements
- R1: After reset, `oe`, `data_valid` and `rdata` are 0 and the state is `PM_IDLE`. Page mode needs no setup: the first read after reset takes the full latency, and a later in-page read takes the page latency.
- R2: The first read after `ce_n` is sampled low raises `data_valid` exactly `FULL_LAT` edges after the edge that sampled it.
- R3: With the page open and `ce_n` low, an address change confined to the low log2(`PAGE_WORDS`) bits raises `data_valid` `PAGE_LAT` edges after the edge that samples it.
- R4: An address change in any bit at or above position log2(`PAGE_WORDS`) closes the page, and the read takes `FULL_LAT` edges.
- R5: `PAGE_WORDS` is 8 by default, making bits 0–2 the page field. With `PAGE_WORDS`=4 only bits 0–1 form the page field, so a change in bit 2 is a page miss.
- R6: One edge after `ce_n` is sampled high, `oe`, `data_valid` and `rdata` are 0 and the page is closed. The next read then takes `FULL_LAT`, even within the former page.
- R7: When `data_valid` rises, `rdata` equals the array word at the sampled address. While the address and `ce_n` stay unchanged, `data_valid` stays 1 and `rdata` stays the same.
- R8: An address change during a wait restarts the count from the edge that samples it. During a full wait any change restarts the full latency. During a page wait an in-page change restarts the page latency.
- R9: A preload write (`ld_we`=1 at an edge) stores `ld_data` at `ld_addr`. It does not alter a word already held on `rdata`, and a later read of that address returns the new word.
- R10: `data_valid` is 0 after the edge that samples any address change, until the applicable latency elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to count access latency |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | ADDR_W | Preload word address |
| ld_data | input | DATA_W | Preload word |
| ce_n | input | 1 | Active-low chip enable |
| addr | input | ADDR_W | Read word address |
| oe | output | 1 | Output driven (0 models high impedance) |
| data_valid | output | 1 | Output word is valid |
| rdata | output | DATA_W | Read data |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default eight-word page and the other a four-word page, both with `FULL_LAT`=5 and `PAGE_LAT`=2 on a 64-word array. Running them together puts the bit-2 change in reach: the same address step is a page hit in one copy and a miss in the other. A page latency of 2 gives a mid-count window for restarting a page wait. A full latency of 5 leaves room to change the address twice inside one full wait.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        PM_IDLE      = 2'd0,
        PM_FULL_WAIT = 2'd1,
        PM_PAGE_WAIT = 2'd2,
        PM_HOLD      = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pm_word_array.sv
module pm_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            cells[ld_addr] <= ld_data;
        end
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/pm_latency_ctr.sv
module pm_latency_ctr #(
    parameter int FULL_LAT = 5,
    parameter int PAGE_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_full,
    input  logic load_page,
    output logic done
);
    localparam int MAX_LAT = (FULL_LAT > PAGE_LAT) ? FULL_LAT : PAGE_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);
    localparam logic [CW-1:0] FULL_RELOAD = CW'(FULL_LAT - 1);
    localparam logic [CW-1:0] PAGE_RELOAD = CW'(PAGE_LAT - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load_full) begin
            remain <= FULL_RELOAD;
        end else if (load_page) begin
            remain <= PAGE_RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

    // R2: a full reload with more than one cycle to go is never done next cycle
    assert_full_not_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_full && (FULL_LAT > 1)) |=> !done);
endmodule

// File: rtl/pm_page_tracker.sv
module pm_page_tracker #(
    parameter int ADDR_W  = 6,
    parameter int PG_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              open_set,
    input  logic              close,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              page_open,
    output logic              moved,
    output logic              in_page
);
    logic [ADDR_W-1:0] tag_match;

    // Bits inside the page field never decide a miss; bits above it must match.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_tag
        if (g < PG_BITS) begin : g_low
            assign tag_match[g] = 1'b1;
        end else begin : g_high
            assign tag_match[g] = (new_addr[g] == cur_addr[g]);
        end
    end

    assign moved   = (new_addr != cur_addr);
    assign in_page = page_open && (&tag_match);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (cap_en) begin
            cur_addr <= new_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_open <= 1'b0;
        end else if (close) begin
            page_open <= 1'b0;
        end else if (open_set) begin
            page_open <= 1'b1;
        end
    end
endmodule

// File: rtl/page_read_port.sv
module page_read_port #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 8,
    parameter int FULL_LAT   = 5,
    parameter int PAGE_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              oe,
    output logic              data_valid,
    output logic [DATA_W-1:0] rdata
);
    import pm_pkg::*;

    localparam int PG_BITS = $clog2(PAGE_WORDS);

    pm_state_e         state, state_nxt;
    logic              cap_en, open_set, close, load_full, load_page;
    logic              cnt_done, moved, in_page, page_open;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] arr_word;

    pm_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (cur_addr),
        .rd_word (arr_word)
    );

    pm_latency_ctr #(.FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_full (load_full),
        .load_page (load_page),
        .done      (cnt_done)
    );

    pm_page_tracker #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .open_set  (open_set),
        .close     (close),
        .new_addr  (addr),
        .cur_addr  (cur_addr),
        .page_open (page_open),
        .moved     (moved),
        .in_page   (in_page)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PM_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_nxt = state;
        cap_en    = 1'b0;
        open_set  = 1'b0;
        close     = 1'b0;
        load_full = 1'b0;
        load_page = 1'b0;
        unique case (state)
            PM_IDLE: begin
                if (!ce_n) begin
                    state_nxt = PM_FULL_WAIT;
                    cap_en    = 1'b1;
                    load_full = 1'b1;
                    close     = 1'b1;
                end
            end
            PM_FULL_WAIT: begin
                if (ce_n) begin
                    state_nxt = PM_IDLE;
                    close     = 1'b1;
                end else if (moved) begin
                    cap_en    = 1'b1;
                    load_full = 1'b1;
                end else if (cnt_done) begin
                    state_nxt = PM_HOLD;
                    open_set  = 1'b1;
                end
            end
            PM_PAGE_WAIT, PM_HOLD: begin
                if (ce_n) begin
                    state_nxt = PM_IDLE;
                    close     = 1'b1;
                end else if (moved) begin
                    cap_en = 1'b1;
                    if (in_page) begin
                        state_nxt = PM_PAGE_WAIT;
                        load_page = 1'b1;
                    end else begin
                        state_nxt = PM_FULL_WAIT;
                        load_full = 1'b1;
                        close     = 1'b1;
                    end
                end else if (state == PM_PAGE_WAIT && cnt_done) begin
                    state_nxt = PM_HOLD;
                end
            end
            default: state_nxt = PM_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe         <= 1'b0;
            data_valid <= 1'b0;
            rdata      <= '0;
        end else begin
            oe         <= (state_nxt != PM_IDLE);
            data_valid <= (state_nxt == PM_HOLD);
            if (state_nxt == PM_IDLE) begin
                rdata <= '0;
            end else if (state_nxt == PM_HOLD && state != PM_HOLD) begin
                rdata <= arr_word;
            end
        end
    end

    assert_valid_needs_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> oe);

    assert_ce_high_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!oe && !data_valid && !page_open && rdata == '0));

    assert_move_drops_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe && addr != cur_addr) |=> !data_valid);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !ce_n && addr == cur_addr) |=> (data_valid && $stable(rdata)));

    assert_rise_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> (rdata == arr_word));

    assert_page_wait_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_PAGE_WAIT) |-> page_open);
endmodule

// File: tb/tb_page_read_port.sv
module tb_page_read_port;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int FL = 5;
    localparam int PL = 2;

    // {address, latency with 8-word pages, latency with 4-word pages}
    localparam logic [13:0] VEC [0:7] = '{
        {6'h10, 4'd5, 4'd5},
        {6'h13, 4'd2, 4'd2},
        {6'h15, 4'd2, 4'd5},
        {6'h17, 4'd2, 4'd2},
        {6'h08, 4'd5, 4'd5},
        {6'h0C, 4'd2, 4'd5},
        {6'h0D, 4'd2, 4'd2},
        {6'h2D, 4'd5, 4'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          ce_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          oe8, v8, oe4, v4;
    logic [DW-1:0] rd8, rd4;
    logic [DW-1:0] model [1 << AW];

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    page_read_port #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(8),
                     .FULL_LAT(FL), .PAGE_LAT(PL)) dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .ce_n(ce_n), .addr(addr),
        .oe(oe8), .data_valid(v8), .rdata(rd8));

    page_read_port #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(4),
                     .FULL_LAT(FL), .PAGE_LAT(PL)) dut_q4 (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .ce_n(ce_n), .addr(addr),
        .oe(oe4), .data_valid(v4), .rdata(rd4));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(posedge clk);
        model[a] = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // Called at a negedge right after an address/enable change was driven.
    task automatic measure(input int e8, input int e4, input logic [AW-1:0] a, input string req);
        int k8 = 0;
        int k4 = 0;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); #1;
            if (k == 1) check(!v8 && !v4, {req, "/R10 valid low after change"}, {v8, v4}, 0);
            if (v8 && k8 == 0) k8 = k - 1;
            if (v4 && k4 == 0) k4 = k - 1;
            if (k8 != 0 && k4 != 0) break;
        end
        check(k8 == e8, {req, " latency 8-word"}, k8, e8);
        check(k4 == e4, {req, " latency 4-word R5"}, k4, e4);
        check(rd8 == model[a], {req, "/R7 data 8-word"}, rd8, model[a]);
        check(rd4 == model[a], {req, "/R7 data 4-word"}, rd4, model[a]);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        for (int i = 0; i < (1 << AW); i++) model[i] = 'x;
        @(negedge clk);
        for (int i = 0; i < (1 << AW); i++) write_word(AW'(i), DW'(16'h3C5A ^ (i * 16'h0123)));
        @(posedge clk); #1;
        check(!oe8 && !v8 && rd8 == '0, "R1 reset 8-word", {oe8, v8}, 0);
        check(!oe4 && !v4 && rd4 == '0, "R1 reset 4-word", {oe4, v4}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 first access, R3 page hits, R4 misses, R5 bit-2 split
        for (int i = 0; i < 8; i++) begin
            addr = VEC[i][13:8];
            ce_n = 1'b0;
            measure(int'(VEC[i][7:4]), int'(VEC[i][3:0]), VEC[i][13:8],
                    (i == 0) ? "R2" : ((VEC[i][7:4] == 4'd2) ? "R3" : "R4"));
        end

        // R7: held word stays valid and stable
        held = rd8;
        repeat (4) @(posedge clk);
        #1;
        check(v8 && rd8 == held, "R7 hold stable", rd8, held);
        @(negedge clk);

        // R6: chip enable high closes the page and turns output off
        ce_n = 1'b1;
        @(posedge clk); #1;
        check(!oe8 && !v8 && rd8 == '0, "R6 output off 8-word", {oe8, v8}, 0);
        check(!oe4 && !v4 && rd4 == '0, "R6 output off 4-word", {oe4, v4}, 0);
        @(negedge clk);
        addr = 6'h2E;
        ce_n = 1'b0;
        measure(FL, FL, 6'h2E, "R6 reopen full");

        // R8: restart inside a full wait
        addr = 6'h30;
        @(posedge clk); @(posedge clk); @(negedge clk);
        addr = 6'h31;
        measure(FL, FL, 6'h31, "R8 full restart");
        // R8: restart inside a page wait
        addr = 6'h32;
        @(posedge clk); @(negedge clk);
        addr = 6'h33;
        measure(PL, PL, 6'h33, "R8 page restart");

        // R9: preload while holding leaves rdata alone, new word read back
        held = rd8;
        write_word(6'h33, 16'hBEEF);
        write_word(6'h34, 16'hCAFE);
        #1;
        check(rd8 == held && v8, "R9 held word untouched", rd8, held);
        addr = 6'h34;
        measure(PL, FL, 6'h34, "R9 read new word");

        // R1: reset mid-operation, first read afterwards is full latency
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(!v8 && !oe8 && !v4 && !oe4, "R1 reset mid-run", {v8, oe8}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(FL, FL, 6'h34, "R1 after reset");
        addr = 6'h35;
        measure(PL, PL, 6'h35, "R1 page mode active");

        finish_run();
    end
endmodule